// File: doc/BRIEF.md
# Two-Wire Bus Master Frame Sequencer

This block is the master-side bit sequencer for an I2C-style two-wire bus. It builds frames in three formats. The first is a 7-bit addressed header. The second is a two-byte 10-bit addressed header. The third is an address-less free format, where the first bits after START are already data. Data words are 1 to 8 bits long, and one ACK slot follows each word. Between words the master may end with a STOP, keep the bus and continue, or issue a repeated START.

Each command is a single pulse that carries its fields: format, slave address, direction, bit count, and start and stop requests. When a command completes without a stop request, the block keeps the bus with SCL held low. The next command then either continues in the same direction or opens a repeated START with a fresh header.

SCL and SDA are driven as open-drain pull-down enables. SCL timing comes from a divider of the system clock, and each bit period is cut into four quarters. The block does not handle multi-master arbitration, slave clock stretching or slave mode.

Top module: `i2c_fs_master`

## Requirements
- R1: After reset, both pull-down enables are off, and busy_o, done_o and nack_o are low.
- R2: Format 0 (7-bit) sends START, then addr[6:0] MSB first, then the direction bit, then one ACK slot released for the slave.
- R3: Format 1 (10-bit) sends START, then 11110, addr[9:8] and 0, then an ACK slot, then addr[7:0], then an ACK slot. When the direction is read (1), it follows with a repeated START, then 11110, addr[9:8] and 1, then an ACK slot, before any data.
- R4: Formats 2 and 3 (free) send data right after START, with no address and no direction bit. cmd_rw_i at START fixes the direction.
- R5: A data word carries cmd_bc_i bits, and a value of 0 means 8 bits. The bits are the top bits of tx_data_i, sent MSB first, and one ACK slot follows.
- R6: A read word shifts the sampled bits MSB first into the low bits of rx_data_o. The master pulls SDA low in the ACK slot, except when the command asks for STOP; then it leaves SDA released.
- R7: With cmd_stop_i high, the command ends in STOP and the bus is released. Otherwise SCL stays low and the bus is kept. On a kept bus, a following command with cmd_start_i low sends data in the direction fixed at the last START and ignores cmd_rw_i. A following command with cmd_start_i high issues a repeated START and a new header.
- R8: A released SDA (high) in the ACK slot of an address byte or a written word sets nack_o. STOP follows at once, and the rest of the command is dropped. nack_o stays set until the next command is accepted.
- R9: SCL high pulses last 2*QDIV clocks. SDA changes while SCL is high only to form START or STOP. The two enables never change in the same clock.
- R10: A cmd_valid_i pulse while busy_o is high is ignored. done_o pulses for one clock when a command finishes, and busy_o is low in that clock.
- R11: A command issued while the bus is released always begins with START, whatever cmd_start_i says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command pulse, taken when busy_o is low |
| cmd_start_i | input | 1 | Issue START or repeated START before the word |
| cmd_stop_i | input | 1 | Issue STOP after the word |
| cmd_fmt_i | input | 2 | 0: 7-bit, 1: 10-bit, 2 or 3: free format |
| cmd_rw_i | input | 1 | Direction at START, 1 = read |
| cmd_addr_i | input | 10 | Slave address (7-bit format uses bits 6:0) |
| cmd_bc_i | input | 3 | Word length, 0 means 8 |
| tx_data_i | input | 8 | Word to write, top bits used |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-clock pulse at command end |
| nack_o | output | 1 | Slave did not acknowledge |
| rx_data_o | output | 8 | Last word read, right-aligned |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
The hardest state to reach is a kept bus that continues without START in read direction. In that state the slave has to drive the first data bit before any SCL edge. The bench must also show that a contradicting cmd_rw_i has no effect there. A bench slave follows a queue of expected bus symbols and drives each slave-owned bit as SCL falls. Directed chains cover the cases that are hard to hit by chance: read, then continue with rw flipped, then stop; a NACK on each of the three header ACK slots; and a 10-bit read with its automatic repeated START. Random commands then mix kept-bus continuations, repeated STARTs and injected NACKs.

// File: rtl/i2c_fs_pkg.sv
package i2c_fs_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned BCW = $clog2(DW);
  localparam int unsigned AW  = 10;
  localparam int unsigned NW  = BCW + 1;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BIT} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_START, ST_BITS, ST_ACK, ST_STOP} st_e;
  typedef enum logic [1:0] {SEG_A1, SEG_A2, SEG_A3, SEG_DAT} seg_e;

  localparam logic [1:0] FMT_A7  = 2'd0;
  localparam logic [1:0] FMT_A10 = 2'd1;
  localparam logic [4:0] HDR10_TAG = 5'b11110;
endpackage

// File: rtl/i2c_fs_qtimer.sv
module i2c_fs_qtimer #(
  parameter int unsigned QDIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic qtick_o
);
  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q;

  assign qtick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || !run_i)     cnt_q <= '0;
    else if (qtick_o)             cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_fs_bit_engine.sv
module i2c_fs_bit_engine
  import i2c_fs_pkg::*;
#(
  parameter int unsigned QDIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  op_e  op_i,
  input  logic wbit_i,
  input  logic sda_i,
  output logic done_o,
  output logic rbit_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);
  logic       active_q, wbit_q, qtick;
  op_e        op_q;
  logic [1:0] ph_q;
  logic       scl_d, sda_d;

  i2c_fs_qtimer #(.QDIV(QDIV)) u_qtimer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active_q),
    .clr_i  (go_i),
    .qtick_o(qtick)
  );

  // quarter-phase line pattern; only one line moves per quarter
  always_comb begin
    scl_d = scl_oe_o;
    sda_d = sda_oe_o;
    unique case (op_q)
      OP_START: begin
        unique case (ph_q)
          2'd0:    begin scl_d = scl_oe_o; sda_d = 1'b0; end
          2'd1:    begin scl_d = 1'b0;     sda_d = 1'b0; end
          2'd2:    begin scl_d = 1'b0;     sda_d = 1'b1; end
          default: begin scl_d = 1'b1;     sda_d = 1'b1; end
        endcase
      end
      OP_STOP: begin
        unique case (ph_q)
          2'd0:    begin scl_d = 1'b1; sda_d = 1'b1; end
          2'd1:    begin scl_d = 1'b0; sda_d = 1'b1; end
          default: begin scl_d = 1'b0; sda_d = 1'b0; end
        endcase
      end
      default: begin
        sda_d = !wbit_q;
        scl_d = (ph_q == 2'd0) || (ph_q == 2'd3);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      op_q     <= OP_BIT;
      wbit_q   <= 1'b1;
      ph_q     <= 2'd0;
      done_o   <= 1'b0;
      rbit_o   <= 1'b1;
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        op_q     <= op_i;
        wbit_q   <= wbit_i;
        ph_q     <= 2'd0;
      end else if (active_q && qtick) begin
        if (ph_q == 2'd2 && op_q == OP_BIT) rbit_o <= sda_i;
        if (ph_q == 2'd3) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          ph_q <= ph_q + 2'd1;
        end
      end
      if (active_q) begin
        scl_oe_o <= scl_d;
        sda_oe_o <= sda_d;
      end
    end
  end
endmodule

// File: rtl/i2c_fs_master.sv
module i2c_fs_master
  import i2c_fs_pkg::*;
#(
  parameter int unsigned QDIV = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic          cmd_start_i,
  input  logic          cmd_stop_i,
  input  logic [1:0]    cmd_fmt_i,
  input  logic          cmd_rw_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [BCW-1:0] cmd_bc_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          nack_o,
  output logic [DW-1:0] rx_data_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  input  logic          sda_i
);
  st_e           st_q;
  seg_e          seg_q;
  logic [1:0]    fmt_q;
  logic [AW-1:0] addr_q;
  logic          dir_q, stop_q, rd_q;
  logic [NW-1:0] n_q, left_q, n_cmd;
  logic [DW-1:0] tx_q, sh_q, rx_q;
  logic          go_q, wbit_q;
  op_e           op_q;
  logic          eng_done, eng_rbit;
  logic [DW-1:0] hdr_a1, hdr_a3, hdr_a2;

  i2c_fs_bit_engine #(.QDIV(QDIV)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go_q),
    .op_i    (op_q),
    .wbit_i  (wbit_q),
    .sda_i   (sda_i),
    .done_o  (eng_done),
    .rbit_o  (eng_rbit),
    .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o)
  );

  assign n_cmd  = (cmd_bc_i == '0) ? NW'(DW) : {1'b0, cmd_bc_i};
  assign hdr_a1 = (fmt_q == FMT_A10) ? {HDR10_TAG, addr_q[9:8], 1'b0}
                                     : {addr_q[6:0], dir_q};
  assign hdr_a2 = addr_q[7:0];
  assign hdr_a3 = {HDR10_TAG, addr_q[9:8], 1'b1};
  assign busy_o = (st_q != ST_IDLE) && (st_q != ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      seg_q     <= SEG_A1;
      fmt_q     <= FMT_A7;
      addr_q    <= '0;
      dir_q     <= 1'b0;
      stop_q    <= 1'b0;
      rd_q      <= 1'b0;
      n_q       <= NW'(DW);
      left_q    <= '0;
      tx_q      <= '0;
      sh_q      <= '0;
      rx_q      <= '0;
      rx_data_o <= '0;
      nack_o    <= 1'b0;
      done_o    <= 1'b0;
      go_q      <= 1'b0;
      op_q      <= OP_BIT;
      wbit_q    <= 1'b1;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE, ST_HOLD: begin
          if (cmd_valid_i) begin
            fmt_q  <= cmd_fmt_i;
            addr_q <= cmd_addr_i;
            stop_q <= cmd_stop_i;
            tx_q   <= tx_data_i;
            n_q    <= n_cmd;
            nack_o <= 1'b0;
            if (cmd_start_i || st_q == ST_IDLE) begin
              dir_q <= cmd_rw_i;
              seg_q <= SEG_A1;
              go_q  <= 1'b1;
              op_q  <= OP_START;
              st_q  <= ST_START;
            end else begin
              // continue on a kept bus in the direction fixed at START
              seg_q  <= SEG_DAT;
              sh_q   <= tx_data_i;
              left_q <= n_cmd;
              rd_q   <= dir_q;
              rx_q   <= '0;
              go_q   <= 1'b1;
              op_q   <= OP_BIT;
              wbit_q <= dir_q ? 1'b1 : tx_data_i[DW-1];
              st_q   <= ST_BITS;
            end
          end
        end
        ST_START: begin
          if (eng_done) begin
            go_q <= 1'b1;
            op_q <= OP_BIT;
            st_q <= ST_BITS;
            rx_q <= '0;
            if (seg_q == SEG_A3) begin
              sh_q   <= hdr_a3;
              left_q <= NW'(DW);
              rd_q   <= 1'b0;
              wbit_q <= hdr_a3[DW-1];
            end else if (fmt_q[1]) begin
              seg_q  <= SEG_DAT;
              sh_q   <= tx_q;
              left_q <= n_q;
              rd_q   <= dir_q;
              wbit_q <= dir_q ? 1'b1 : tx_q[DW-1];
            end else begin
              sh_q   <= hdr_a1;
              left_q <= NW'(DW);
              rd_q   <= 1'b0;
              wbit_q <= hdr_a1[DW-1];
            end
          end
        end
        ST_BITS: begin
          if (eng_done) begin
            if (rd_q) rx_q <= {rx_q[DW-2:0], eng_rbit};
            sh_q   <= sh_q << 1;
            left_q <= left_q - 1'b1;
            go_q   <= 1'b1;
            op_q   <= OP_BIT;
            if (left_q == NW'(1)) begin
              // ACK slot: release on write, master ACK/NACK on read
              wbit_q <= rd_q ? stop_q : 1'b1;
              st_q   <= ST_ACK;
            end else begin
              wbit_q <= rd_q ? 1'b1 : sh_q[DW-2];
            end
          end
        end
        ST_ACK: begin
          if (eng_done) begin
            if (!rd_q && eng_rbit) begin
              nack_o <= 1'b1;
              go_q   <= 1'b1;
              op_q   <= OP_STOP;
              st_q   <= ST_STOP;
            end else begin
              unique case (seg_q)
                SEG_A1: begin
                  go_q <= 1'b1;
                  op_q <= OP_BIT;
                  st_q <= ST_BITS;
                  rx_q <= '0;
                  if (fmt_q == FMT_A10) begin
                    seg_q  <= SEG_A2;
                    sh_q   <= hdr_a2;
                    left_q <= NW'(DW);
                    rd_q   <= 1'b0;
                    wbit_q <= hdr_a2[DW-1];
                  end else begin
                    seg_q  <= SEG_DAT;
                    sh_q   <= tx_q;
                    left_q <= n_q;
                    rd_q   <= dir_q;
                    wbit_q <= dir_q ? 1'b1 : tx_q[DW-1];
                  end
                end
                SEG_A2: begin
                  go_q <= 1'b1;
                  if (dir_q) begin
                    seg_q <= SEG_A3;
                    op_q  <= OP_START;
                    st_q  <= ST_START;
                  end else begin
                    seg_q  <= SEG_DAT;
                    op_q   <= OP_BIT;
                    st_q   <= ST_BITS;
                    sh_q   <= tx_q;
                    left_q <= n_q;
                    rd_q   <= 1'b0;
                    rx_q   <= '0;
                    wbit_q <= tx_q[DW-1];
                  end
                end
                SEG_A3: begin
                  seg_q  <= SEG_DAT;
                  go_q   <= 1'b1;
                  op_q   <= OP_BIT;
                  st_q   <= ST_BITS;
                  sh_q   <= tx_q;
                  left_q <= n_q;
                  rd_q   <= 1'b1;
                  rx_q   <= '0;
                  wbit_q <= 1'b1;
                end
                default: begin
                  if (rd_q) rx_data_o <= rx_q;
                  if (stop_q) begin
                    go_q <= 1'b1;
                    op_q <= OP_STOP;
                    st_q <= ST_STOP;
                  end else begin
                    st_q   <= ST_HOLD;
                    done_o <= 1'b1;
                  end
                end
              endcase
            end
          end
        end
        ST_STOP: begin
          if (eng_done) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_fs_master_chk.sv
module i2c_fs_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic nack_o,
  input logic scl_oe_o,
  input logic sda_oe_o
);
  p_one_line_moves_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((scl_oe_o != $past(scl_oe_o)) && (sda_oe_o != $past(sda_oe_o))));

  p_quiet_when_free_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cmd_valid_i) |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_not_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_nack_in_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_o) |-> busy_o);

  p_released_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !scl_oe_o) |-> !sda_oe_o);
endmodule

bind i2c_fs_master i2c_fs_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .nack_o     (nack_o),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o)
);

// File: tb/tb_i2c_fs_master.sv
`timescale 1ns/1ps
module tb_i2c_fs_master;
  localparam int QDIV = 4;
  localparam int K_S = 0, K_P = 1, K_M = 2, K_A = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_start = 0, cmd_stop = 0, cmd_rw = 0;
  logic [1:0] cmd_fmt = 0;
  logic [9:0] cmd_addr = 0;
  logic [2:0] cmd_bc = 0;
  logic [7:0] tx_data = 0;
  logic busy, done, nack, scl_oe, sda_oe;
  logic [7:0] rx_data;
  logic slv_pull = 1'b0;
  wire  scl_line = !scl_oe;
  wire  sda_line = !(sda_oe || slv_pull);

  int checks = 0, fails = 0, cyc = 0;
  int exp_kind [0:63];
  bit exp_val  [0:63];
  int exp_len = 0, pos = 0, seq_err = 0, hi_bad = 0, ack_idx = 0;
  bit armed = 0, hi_flag = 0, hi_val = 0, nacked = 0;
  bit bm_held = 0, bm_dir = 0;
  int hi_t = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  i2c_fs_master #(.QDIV(QDIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_start_i(cmd_start),
    .cmd_stop_i(cmd_stop), .cmd_fmt_i(cmd_fmt), .cmd_rw_i(cmd_rw), .cmd_addr_i(cmd_addr),
    .cmd_bc_i(cmd_bc), .tx_data_i(tx_data), .busy_o(busy), .done_o(done), .nack_o(nack),
    .rx_data_o(rx_data), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic log_item(input int k, input bit v);
    if (pos >= exp_len) seq_err++;
    else if (k == K_S || k == K_P) begin if (exp_kind[pos] != k) seq_err++; end
    else if ((exp_kind[pos] != K_M && exp_kind[pos] != K_A) || exp_val[pos] != v) seq_err++;
    pos++;
  endtask

  always @(posedge scl_line) if (armed) begin hi_flag = 1; hi_val = sda_line; hi_t = cyc; end
  always @(negedge scl_line) if (armed) begin
    if (hi_flag) begin
      log_item(K_M, hi_val);
      if (cyc - hi_t != 2 * QDIV) hi_bad++;
    end
    hi_flag = 0;
    slv_pull = (pos < exp_len) && exp_kind[pos] == K_A && exp_val[pos] == 1'b0;
  end
  always @(sda_line) if (armed && scl_line === 1'b1) begin
    log_item(sda_line ? K_P : K_S, 1'b0);
    hi_flag = 0;
  end

  task automatic push(input int k, input bit v);
    exp_kind[exp_len] = k; exp_val[exp_len] = v; exp_len++;
  endtask
  task automatic push_bits(input bit [7:0] b, input int n, input int k);
    for (int i = 0; i < n; i++) push(k, b[7-i]);
  endtask
  task automatic push_ack(input int nack_slot);
    ack_idx++;
    if (ack_idx == nack_slot) begin push(K_A, 1'b1); nacked = 1; end
    else push(K_A, 1'b0);
  endtask

  task automatic run_cmd(input bit st, input bit sp, input bit [1:0] fmt, input bit rw,
                         input bit [9:0] addr, input bit [2:0] bc, input bit [7:0] tx,
                         input bit [7:0] sbyte, input int nack_slot, input bit poke,
                         input string tag);
    int n;
    bit [7:0] exp_rx;
    bit rd;
    n = (bc == 0) ? 8 : int'(bc);
    exp_len = 0; pos = 0; seq_err = 0; ack_idx = 0; nacked = 0; rd = 0;
    if (st || !bm_held) begin
      push(K_S, 0);
      bm_dir = rw;
      if (fmt == 2'd0) begin
        push_bits({addr[6:0], rw}, 8, K_M); push_ack(nack_slot);
      end else if (fmt == 2'd1) begin
        push_bits({5'b11110, addr[9:8], 1'b0}, 8, K_M); push_ack(nack_slot);
        if (!nacked) begin push_bits(addr[7:0], 8, K_M); push_ack(nack_slot); end
        if (!nacked && rw) begin
          push(K_S, 0); push_bits({5'b11110, addr[9:8], 1'b1}, 8, K_M); push_ack(nack_slot);
        end
      end
    end
    if (!nacked) begin
      if (!bm_dir) begin push_bits(tx, n, K_M); push_ack(nack_slot); end
      else begin push_bits(sbyte, n, K_A); push(K_M, sp); rd = 1; end
    end
    if (nacked || sp) begin push(K_P, 0); bm_held = 0; end
    else bm_held = 1;
    exp_rx = sbyte >> (8 - n);

    @(negedge clk);
    slv_pull = exp_kind[0] == K_A && exp_val[0] == 1'b0;
    cmd_start = st; cmd_stop = sp; cmd_fmt = fmt; cmd_rw = rw; cmd_addr = addr;
    cmd_bc = bc; tx_data = tx; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R10 busy during command", busy, 1);
      cmd_start = 1; cmd_stop = ~sp; cmd_fmt = ~fmt; cmd_rw = ~rw; tx_data = ~tx;
      cmd_addr = ~addr; cmd_valid = 1;
      @(negedge clk);
      cmd_valid = 0;
    end
    while (!done) @(negedge clk);
    chk(seq_err == 0 && pos == exp_len, tag, pos, exp_len);
    chk(nack == nacked, "R8 nack flag", nack, nacked);
    chk(busy == 1'b0, "R10 busy low at done", busy, 0);
    if (rd) chk(rx_data == exp_rx, "R6 read word", rx_data, exp_rx);
    if (bm_held) chk(scl_oe == 1'b1, "R7 bus kept with SCL low", scl_oe, 1);
    else chk(!scl_oe && !sda_oe, "R7 bus released after STOP", {scl_oe, sda_oe}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single pulse", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !nack, "R1 reset state",
        {scl_oe, sda_oe, busy, done, nack}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    armed = 1;

    run_cmd(1, 1, 2'd0, 0, 10'h05A, 3'd0, 8'hC3, 8'h00, 0, 0, "R2 7-bit write 8 bits");
    run_cmd(1, 0, 2'd0, 1, 10'h013, 3'd3, 8'h00, 8'hA5, 0, 0, "R6 7-bit read 3 bits kept");
    run_cmd(0, 1, 2'd0, 0, 10'h013, 3'd5, 8'hFF, 8'h37, 0, 0, "R7 continue read rw ignored");
    run_cmd(1, 0, 2'd1, 0, 10'h2B6, 3'd0, 8'h9E, 8'h00, 0, 0, "R3 10-bit write");
    run_cmd(1, 1, 2'd1, 1, 10'h2B6, 3'd6, 8'h00, 8'h6C, 0, 0, "R3 10-bit read repeated START");
    run_cmd(1, 0, 2'd2, 0, 10'h000, 3'd1, 8'h80, 8'h00, 0, 0, "R4 free write 1 bit");
    run_cmd(0, 0, 2'd3, 1, 10'h3FF, 3'd7, 8'h5B, 8'h00, 0, 0, "R5 free continue 7 bits");
    run_cmd(1, 1, 2'd3, 1, 10'h000, 3'd4, 8'h00, 8'hF0, 0, 0, "R4 free repeated START read");
    run_cmd(0, 1, 2'd0, 0, 10'h071, 3'd2, 8'h40, 8'h00, 0, 0, "R11 start forced on idle bus");
    run_cmd(1, 1, 2'd0, 0, 10'h044, 3'd0, 8'h11, 8'h00, 1, 0, "R8 nack on 7-bit address");
    run_cmd(1, 1, 2'd1, 1, 10'h155, 3'd0, 8'h00, 8'h22, 2, 0, "R8 nack on 10-bit low byte");
    run_cmd(1, 1, 2'd1, 1, 10'h155, 3'd0, 8'h00, 8'h22, 3, 0, "R8 nack on 10-bit read header");
    run_cmd(1, 1, 2'd0, 0, 10'h044, 3'd0, 8'h11, 8'h00, 2, 0, "R8 nack on write data");
    run_cmd(1, 1, 2'd0, 0, 10'h06E, 3'd0, 8'hA9, 8'h00, 0, 1, "R10 command while busy ignored");

    for (int k = 0; k < 60; k++) begin
      bit st, sp, rw; bit [1:0] fmt; bit [9:0] addr; bit [2:0] bc;
      bit [7:0] tx, sb; int ns;
      st = ($urandom % 3) == 0; sp = ($urandom % 3) == 0; rw = $urandom % 2;
      fmt = $urandom % 4; addr = $urandom % 1024; bc = $urandom % 8;
      tx = $urandom % 256; sb = $urandom % 256;
      ns = (($urandom % 6) == 0) ? 1 + ($urandom % 3) : 0;
      run_cmd(st, sp, fmt, rw, addr, bc, tx, sb, ns, ($urandom % 8) == 0, "R5 random frame");
    end
    if (bm_held) run_cmd(0, 1, 2'd0, 0, 10'h0, 3'd1, 8'h00, 8'h00, 0, 0, "R7 final stop");

    chk(hi_bad == 0, "R9 SCL high width", hi_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule